// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Interval Refresh

This block drives an asynchronous dynamic memory whose row and column addresses are time-multiplexed onto one narrow address bus. A host issues single-word reads and writes with a full word address. The controller splits that address into a row part and a column part. It puts the row on the pins first and drops the active-low row strobe. It then puts the column on the pins and drops the active-low column strobe. A write drives the data bus with the write-enable low. A read samples the returned data a fixed number of cycles into the column strobe.

After an access the row stays open. A later request to the same row is served with only a column strobe pulse, which is page mode. A request to a different row first raises the row strobe for a programmable precharge time and then opens the new row. A free-running interval timer raises a refresh request. That request wins over any new host request. It closes an open row, then runs a refresh cycle in which the column strobe falls one cycle before the row strobe, so the memory's own row counter picks the row to refresh.

The host holds `req_i`, `we_i`, `addr_i` and `wdata_i` steady until `done_o` pulses, then may drop or change them.

Top module: `pagedram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both strobes and the write-enable are high, `done_o` is low and the data bus is not driven.
- R2: The row is the upper ROW_W bits of the word address and the column is the lower COL_W bits. Each is zero-extended to the pin width. The pins carry the row when the row strobe falls and the column when the column strobe falls.
- R3: On every row opening, the column strobe falls exactly T_RCD+1 cycles after the row strobe falls.
- R4: For a host access the column strobe stays low for exactly T_CAS cycles.
- R5: A write holds the write-enable low and drives `wdata_i` on the data bus whenever the column strobe is low. A read captures the bus T_RD cycles after the column strobe falls and presents it on `rdata_o`. Every request is answered by a `done_o` pulse one cycle wide.
- R6: A request whose row equals the open row is served without any movement of the row strobe. In a row-major sweep, a row is opened once per row, plus at most once per refresh.
- R7: A request to another row raises the row strobe for at least T_RP cycles before the new row opens. In a sweep where every access changes row, exactly one opening occurs per access.
- R8: A refresh drops the column strobe one cycle before the row strobe. It then holds the row strobe low for exactly T_REFR cycles, with the column strobe low for T_REFR+1 cycles.
- R9: Refresh cycles start once per REF_INTERVAL clock cycles when the host is idle.
- R10: A pending refresh blocks acceptance of any host request. It starts only with the row closed, after the row strobe has been high for at least T_RP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Host request, held until done |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ROW_W+COL_W | Word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid with done |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address pins |
| mem_ras_n_o | output | 1 | Row strobe, active low |
| mem_cas_n_o | output | 1 | Column strobe, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_dq_o | output | DW | Data driven to memory |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | DW | Data returned by memory |

## Verification
The bench attaches a behavioural memory model and sweeps every address of a 64-word configuration. It writes in row-major order, reads back in column-major order, then interleaves writes and page-hit reads. A controller that put the column half on the pins at row time, or swapped the halves, would return data from the wrong cells. A controller that reopened the row on a page hit would show extra row openings, and one that missed a row change would read the old row. The model times each strobe edge in cycles, so a wrong precharge, row-to-column delay or strobe width shows up as a wrong count. It also flags a refresh whose column strobe does not lead the row strobe by exactly one cycle. An idle window measures the refresh rate, which catches an interval timer that runs off by a whole period.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,   // row closed, strobes high
    ST_RSET,   // row address on pins, row strobe still high
    ST_RCD,    // row strobe low, waiting before column
    ST_CSET,   // column address on pins, column strobe high
    ST_COL,    // column strobe low
    ST_CPH,    // column strobe high after an access
    ST_OPEN,   // row held open, waiting
    ST_PRE,    // row strobe high, precharge
    ST_REFC,   // refresh: column strobe low first
    ST_REFR    // refresh: both strobes low
  } pdc_state_e;

  // load value for a down counter that must last n cycles
  function automatic int span_load(input int n);
    return (n < 1) ? 0 : n - 1;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pdc_refresh_timer.sv
module pdc_refresh_timer #(
  parameter int REF_INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_start_i,
  output logic ref_pend_o,
  output logic ref_tick_o
);
  localparam int TW = $clog2(REF_INTERVAL + 1);

  logic [TW-1:0] tmr_q;

  assign ref_tick_o = (tmr_q == TW'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q      <= '0;
      ref_pend_o <= 1'b0;
    end else begin
      tmr_q <= ref_tick_o ? '0 : tmr_q + 1'b1;
      if (ref_tick_o)
        ref_pend_o <= 1'b1;
      else if (ref_start_i)
        ref_pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pdc_addr_path.sv
module pdc_addr_path
  import pdc_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int DW    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept_i,
  input  logic                   col_sel_i,
  input  logic                   wr_phase_i,
  input  logic                   rd_sample_i,
  input  logic                   we_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [DW-1:0]          mem_dq_i,
  output logic                   hit_o,
  output logic                   cap_we_o,
  output logic [DW-1:0]          rdata_o,
  output logic [max2(ROW_W,COL_W)-1:0] mem_addr_o,
  output logic                   mem_we_n_o,
  output logic [DW-1:0]          mem_dq_o,
  output logic                   mem_dq_oe_o
);
  localparam int AW = ROW_W + COL_W;
  localparam int PW = max2(ROW_W, COL_W);

  function automatic logic [ROW_W-1:0] row_of(input logic [AW-1:0] a);
    return a[AW-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [AW-1:0] a);
    return a[COL_W-1:0];
  endfunction

  function automatic logic [PW-1:0] row_pins(input logic [AW-1:0] a);
    logic [PW-1:0] p;
    p = '0;
    p[ROW_W-1:0] = row_of(a);
    return p;
  endfunction

  function automatic logic [PW-1:0] col_pins(input logic [AW-1:0] a);
    logic [PW-1:0] p;
    p = '0;
    p[COL_W-1:0] = col_of(a);
    return p;
  endfunction

  logic [AW-1:0] cap_addr_q;
  logic [DW-1:0] cap_wdata_q;
  logic          cap_we_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr_q  <= '0;
      cap_wdata_q <= '0;
      cap_we_q    <= 1'b0;
      rdata_o     <= '0;
    end else begin
      if (accept_i) begin
        cap_addr_q  <= addr_i;
        cap_wdata_q <= wdata_i;
        cap_we_q    <= we_i;
      end
      if (rd_sample_i && !cap_we_q)
        rdata_o <= mem_dq_i;
    end
  end

  // while a row is open the captured address holds that row
  assign hit_o       = (row_of(addr_i) == row_of(cap_addr_q));
  assign cap_we_o    = cap_we_q;
  assign mem_addr_o  = col_sel_i ? col_pins(cap_addr_q) : row_pins(cap_addr_q);
  assign mem_we_n_o  = !(wr_phase_i && cap_we_q);
  assign mem_dq_oe_o = wr_phase_i && cap_we_q;
  assign mem_dq_o    = cap_wdata_q;
endmodule

// File: rtl/pdc_sequencer.sv
module pdc_sequencer
  import pdc_pkg::*;
#(
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 3,
  parameter int T_RD   = 2,
  parameter int T_CP   = 1,
  parameter int T_RP   = 3,
  parameter int T_REFR = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic hit_i,
  input  logic ref_pend_i,
  output logic accept_o,
  output logic page_hit_o,
  output logic ref_start_o,
  output logic rd_sample_o,
  output logic col_sel_o,
  output logic wr_phase_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic done_o
);
  localparam int MAXT = max2(max2(max2(T_RCD, T_CAS), max2(T_CP, T_RP)), T_REFR);
  localparam int CW   = $clog2(MAXT + 1) + 1;

  pdc_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  assign accept_o    = req_i && !ref_pend_i &&
                       ((st_q == ST_IDLE) || (st_q == ST_OPEN && hit_i));
  assign page_hit_o  = (st_q == ST_OPEN) && req_i && !ref_pend_i && hit_i;
  assign ref_start_o = (st_q == ST_IDLE) && ref_pend_i;
  assign rd_sample_o = (st_q == ST_COL) && (cnt_q == CW'(T_CAS - T_RD));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_zero ? cnt_q : cnt_q - 1'b1;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_pend_i) begin
          st_d = ST_REFC; cnt_d = '0;
        end else if (req_i) begin
          st_d = ST_RSET; cnt_d = '0;
        end
      end
      ST_RSET: begin
        st_d = ST_RCD; cnt_d = CW'(span_load(T_RCD));
      end
      ST_RCD: if (cnt_zero) begin
        st_d = ST_CSET; cnt_d = '0;
      end
      ST_CSET: begin
        st_d = ST_COL; cnt_d = CW'(span_load(T_CAS));
      end
      ST_COL: if (cnt_zero) begin
        st_d = ST_CPH; cnt_d = CW'(span_load(T_CP)); done_d = 1'b1;
      end
      ST_CPH: if (cnt_zero) st_d = ST_OPEN;
      ST_OPEN: begin
        if (ref_pend_i || (req_i && !hit_i)) begin
          st_d = ST_PRE; cnt_d = CW'(span_load(T_RP));
        end else if (req_i) begin
          st_d = ST_CSET; cnt_d = '0;
        end
      end
      ST_PRE: if (cnt_zero) st_d = ST_IDLE;
      ST_REFC: begin
        st_d = ST_REFR; cnt_d = CW'(span_load(T_REFR));
      end
      ST_REFR: if (cnt_zero) begin
        st_d = ST_PRE; cnt_d = CW'(span_load(T_RP));
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_o <= done_d;
    end
  end

  // strobe and bus decode from the registered state
  always_comb begin
    ras_n_o    = 1'b1;
    cas_n_o    = 1'b1;
    col_sel_o  = 1'b0;
    wr_phase_o = 1'b0;
    unique case (st_q)
      ST_RCD:  ras_n_o = 1'b0;
      ST_CSET: begin ras_n_o = 1'b0; col_sel_o = 1'b1; wr_phase_o = 1'b1; end
      ST_COL:  begin ras_n_o = 1'b0; cas_n_o = 1'b0; col_sel_o = 1'b1; wr_phase_o = 1'b1; end
      ST_CPH, ST_OPEN: begin ras_n_o = 1'b0; col_sel_o = 1'b1; end
      ST_REFC: cas_n_o = 1'b0;
      ST_REFR: begin ras_n_o = 1'b0; cas_n_o = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/pagedram_ctrl.sv
module pagedram_ctrl
  import pdc_pkg::*;
#(
  parameter int ROW_W        = 10,
  parameter int COL_W        = 10,
  parameter int DW           = 16,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 3,
  parameter int T_RD         = 2,
  parameter int T_CP         = 1,
  parameter int T_RP         = 3,
  parameter int T_REFR       = 4,
  parameter int REF_INTERVAL = 780
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ROW_W+COL_W-1:0]        addr_i,
  input  logic [DW-1:0]                 wdata_i,
  output logic [DW-1:0]                 rdata_o,
  output logic                          done_o,
  output logic [max2(ROW_W,COL_W)-1:0]  mem_addr_o,
  output logic                          mem_ras_n_o,
  output logic                          mem_cas_n_o,
  output logic                          mem_we_n_o,
  output logic [DW-1:0]                 mem_dq_o,
  output logic                          mem_dq_oe_o,
  input  logic [DW-1:0]                 mem_dq_i
);
  // named internal events, watched by the bound checker
  logic ref_pend;
  logic ref_tick;
  logic ref_start;
  logic accept;
  logic page_hit;
  logic rd_sample;
  logic hit;
  logic col_sel;
  logic wr_phase;
  logic cap_we;

  pdc_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_tmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_start_i (ref_start),
    .ref_pend_o  (ref_pend),
    .ref_tick_o  (ref_tick)
  );

  pdc_sequencer #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RD(T_RD),
    .T_CP(T_CP), .T_RP(T_RP), .T_REFR(T_REFR)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .hit_i       (hit),
    .ref_pend_i  (ref_pend),
    .accept_o    (accept),
    .page_hit_o  (page_hit),
    .ref_start_o (ref_start),
    .rd_sample_o (rd_sample),
    .col_sel_o   (col_sel),
    .wr_phase_o  (wr_phase),
    .ras_n_o     (mem_ras_n_o),
    .cas_n_o     (mem_cas_n_o),
    .done_o      (done_o)
  );

  pdc_addr_path #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_ap (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .col_sel_i   (col_sel),
    .wr_phase_i  (wr_phase),
    .rd_sample_i (rd_sample),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .mem_dq_i    (mem_dq_i),
    .hit_o       (hit),
    .cap_we_o    (cap_we),
    .rdata_o     (rdata_o),
    .mem_addr_o  (mem_addr_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o)
  );
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk #(
  parameter int T_CAS = 3,
  parameter int T_RP  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic dq_oe,
  input logic done,
  input logic ref_pend,
  input logic ref_start,
  input logic accept,
  input logic page_hit,
  input logic rd_sample
);
  localparam int HW = $clog2(T_RP + 2) + 1;
  localparam int LW = $clog2(T_CAS + 2) + 1;

  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= HW'(T_RP);
      lo_cnt <= '0;
    end else begin
      if (!ras_n) hi_cnt <= '0;
      else if (hi_cnt < HW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
      if (cas_n) lo_cnt <= '0;
      else if (lo_cnt < LW'(T_CAS)) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  // R8
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && ras_n) |=> ($fell(ras_n) && !cas_n));

  // R7
  ras_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= HW'(T_RP)));

  // R4
  cas_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> (lo_cnt >= LW'(T_CAS)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && !ras_n && !we_n) |-> dq_oe);

  // R5
  oe_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);

  // R5
  rd_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sample |-> (!cas_n && !ras_n));

  // R6
  hit_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_hit |-> (!ras_n ##1 !ras_n));

  // R10
  ref_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !accept);

  // R10
  ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_start |-> (ras_n && cas_n && hi_cnt >= HW'(T_RP)));
endmodule

bind pagedram_ctrl pdc_chk #(.T_CAS(T_CAS), .T_RP(T_RP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras_n     (mem_ras_n_o),
  .cas_n     (mem_cas_n_o),
  .we_n      (mem_we_n_o),
  .dq_oe     (mem_dq_oe_o),
  .done      (done_o),
  .ref_pend  (ref_pend),
  .ref_start (ref_start),
  .accept    (accept),
  .page_hit  (page_hit),
  .rd_sample (rd_sample)
);

// File: tb/pagedram_ctrl_tb.sv
`timescale 1ns/1ps
module pagedram_ctrl_tb;
  localparam int ROW_W = 3;
  localparam int COL_W = 3;
  localparam int AW    = ROW_W + COL_W;
  localparam int PW    = 3;
  localparam int DW    = 8;
  localparam int T_RCD = 2;
  localparam int T_CAS = 3;
  localparam int T_RD  = 2;
  localparam int T_CP  = 1;
  localparam int T_RP  = 2;
  localparam int T_REFR = 3;
  localparam int REF_INTERVAL = 60;
  localparam int NWORD = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic done;
  logic [PW-1:0] maddr;
  logic ras_n, cas_n, we_n, dq_oe;
  logic [DW-1:0] dq_o;
  logic [DW-1:0] dq_i = 8'hA5;

  always #2 clk = ~clk;  // 250 MHz

  pagedram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RD(T_RD), .T_CP(T_CP), .T_RP(T_RP), .T_REFR(T_REFR),
    .REF_INTERVAL(REF_INTERVAL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .mem_addr_o(maddr),
    .mem_ras_n_o(ras_n), .mem_cas_n_o(cas_n), .mem_we_n_o(we_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 29 + 7 + salt * 101) & 8'hFF);
  endfunction

  // ---------------- memory model ----------------
  logic [DW-1:0] mem [NWORD];
  logic [ROW_W-1:0] cur_row = '0;
  logic pr_ras = 1'b1, pr_cas = 1'b1;
  logic in_ref = 1'b0, fresh = 1'b0;
  int ras_hi = 100, ras_lo = 0, cas_lo = 0, cas_age = 100, since_ras = 0;
  int act_cnt = 0, ref_cnt = 0;
  logic [PW-1:0] exp_row = '0, exp_col = '0;
  logic [DW-1:0] exp_wd = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic ras_fell = pr_ras && !ras_n;
      automatic logic ras_rose = !pr_ras && ras_n;
      automatic logic cas_fell = pr_cas && !cas_n;
      automatic logic cas_rose = !pr_cas && cas_n;
      if (ras_n) ras_hi = ras_rose ? 1 : ras_hi + 1;
      else begin
        ras_lo    = ras_fell ? 1 : ras_lo + 1;
        since_ras = ras_fell ? 0 : since_ras + 1;
      end
      if (!cas_n) cas_lo = cas_fell ? 1 : cas_lo + 1;
      cas_age = cas_fell ? 0 : cas_age + 1;

      if (ras_fell) begin
        if (!cas_n) begin
          ref_cnt++;
          in_ref = 1'b1;
          chk(cas_age == 1, "R8 cbr lead", cas_age, 1);
          chk(ras_hi >= T_RP, "R10 closed before refresh", ras_hi, T_RP);
        end else begin
          act_cnt++;
          in_ref  = 1'b0;
          fresh   = 1'b1;
          cur_row = maddr[ROW_W-1:0];
          chk(maddr == exp_row, "R2 row pins", maddr, exp_row);
          chk(ras_hi >= T_RP, "R7 precharge", ras_hi, T_RP);
        end
      end
      if (ras_rose && in_ref) chk(ras_lo == T_REFR, "R8 ref ras width", ras_lo, T_REFR);
      if (cas_fell && !ras_n) begin
        chk(maddr == exp_col, "R2 col pins", maddr, exp_col);
        if (fresh) chk(since_ras == T_RCD + 1, "R3 ras-to-cas", since_ras, T_RCD + 1);
        fresh = 1'b0;
        if (!we_n) begin
          chk(dq_oe && dq_o == exp_wd, "R5 write data", dq_o, exp_wd);
          mem[{cur_row, maddr[COL_W-1:0]}] = dq_o;
        end else begin
          dq_i = mem[{cur_row, maddr[COL_W-1:0]}];
        end
      end
      if (!cas_n && !we_n) chk(dq_oe == 1'b1, "R5 bus driven", dq_oe, 1);
      if (cas_rose) begin
        if (in_ref) chk(cas_lo == T_REFR + 1, "R8 ref cas width", cas_lo, T_REFR + 1);
        else        chk(cas_lo == T_CAS, "R4 cas width", cas_lo, T_CAS);
        dq_i = 8'hA5;
      end
      pr_ras = ras_n;
      pr_cas = cas_n;
    end
  end

  // ---------------- host ----------------
  task automatic access(input logic w, input int a, input logic [DW-1:0] d,
                        output logic [DW-1:0] r);
    int dn;
    @(negedge clk);
    req = 1'b1; we = w; addr = AW'(a); wdata = d;
    exp_row = PW'(a >> COL_W); exp_col = PW'(a & ((1 << COL_W) - 1)); exp_wd = d;
    do @(negedge clk); while (!done);
    r = rdata;
    req = 1'b0;
    @(negedge clk);
    dn = done;
    chk(dn == 0, "R5 done one cycle", dn, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] r;
    int a0, r0, span;
    for (int i = 0; i < NWORD; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7);
    chk(!done && !dq_oe, "R1 done/oe in reset", {done, dq_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && !done && !dq_oe, "R1 after reset", {ras_n, cas_n, done, dq_oe}, 12);

    // row-major writes: page hits within each row (R6)
    a0 = act_cnt; r0 = ref_cnt;
    for (int a = 0; a < NWORD; a++) access(1'b1, a, pat(a, 0), r);
    chk(act_cnt - a0 >= (1 << ROW_W), "R6 openings lower", act_cnt - a0, 1 << ROW_W);
    chk(act_cnt - a0 <= (1 << ROW_W) + (ref_cnt - r0), "R6 openings upper",
        act_cnt - a0, (1 << ROW_W) + (ref_cnt - r0));
    chk(ref_cnt - r0 > 0, "R10 refresh interleaved", ref_cnt - r0, 1);

    // column-major reads: every access changes row (R7)
    a0 = act_cnt;
    for (int c = 0; c < (1 << COL_W); c++)
      for (int rw = 0; rw < (1 << ROW_W); rw++) begin
        int a;
        a = (rw << COL_W) | c;
        access(1'b0, a, 8'h00, r);
        chk(r == pat(a, 0), "R5 read back", r, pat(a, 0));
      end
    chk(act_cnt - a0 == NWORD, "R7 one opening per access", act_cnt - a0, NWORD);

    // interleaved write then page-hit read of the same word
    for (int a = 0; a < NWORD; a += 3) begin
      access(1'b1, a, pat(a, 1), r);
      access(1'b0, a, 8'h00, r);
      chk(r == pat(a, 1), "R6 page-hit read after write", r, pat(a, 1));
    end

    // idle window: refresh rate (R9)
    r0 = ref_cnt;
    span = 20;
    repeat (span * REF_INTERVAL) @(negedge clk);
    chk(ref_cnt - r0 >= span - 1 && ref_cnt - r0 <= span + 1, "R9 refresh rate",
        ref_cnt - r0, span);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule